// File: doc/BRIEF.md
# Two-Step Adaptive Baseline Restorer

The block removes a slowly drifting baseline from a stream of signed per-bucket samples before they reach an intensity integrator. A sample counts as baseline when it carries no beam peak. Two configuration values separate peaks from baseline: a window length in samples, which separates slow drift from peaks in time, and a signed threshold, which separates them in amplitude.

The first stage finds the smallest sample in each window. It keeps a running average of the most recent window minima, and this average is the floor estimate. The second stage subtracts the floor from each incoming sample. It treats a floor-corrected sample that lies under the threshold as a baseline point and keeps a moving average of those points, which is the final baseline. The corrected output is the floor-corrected sample minus the final baseline. Both estimates are brought out so that the surrounding logic can monitor them.

Top module: `bl_restorer`

## Requirements
- R1: While rst_ni is low, and until the first accepted sample, out_valid_o, out_o, floor_o and base_o are all 0.
- R2: A window spans win_len_i accepted samples, and a value of 0 counts as 1. The floor averager receives one new entry per window, on the window's last sample. That entry is the signed minimum of the samples in the window.
- R3: floor_o is the sum of the most recent window minima, up to 64 of them, divided by their number and truncated toward zero. It is 0 before the first window closes. It updates on the clock edge that accepts the closing sample.
- R4: Each accepted sample forms diff = saturate(smp_i - floor_o), using floor_o as it was before that sample. When diff < thresh_i (signed comparison), diff enters the baseline averager.
- R5: base_o is the sum of the most recent entries in the baseline averager, up to 64 of them, divided by their number and truncated toward zero. It is 0 while the averager is empty.
- R6: An accepted sample whose diff is at or above thresh_i leaves base_o unchanged.
- R7: On the edge that accepts a sample, out_valid_o goes to 1 for one cycle and out_o takes the value saturate(diff - base_o), using base_o as it was before that sample.
- R8: Every subtraction clamps to the signed range of the sample width, -32768 to 32767 at the default width of 16, and never wraps.
- R9: A cycle with smp_valid_i low sets out_valid_o to 0 and leaves out_o, floor_o and base_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | An input sample is present this cycle |
| smp_i | input | SMP_W | Signed per-bucket sample |
| win_len_i | input | WIN_W | Window length in samples for the minimum search (0 counts as 1) |
| thresh_i | input | SMP_W | Signed threshold on the floor-corrected sample |
| out_valid_o | output | 1 | Corrected sample is valid |
| out_o | output | SMP_W | Signed corrected sample |
| floor_o | output | SMP_W | Floor estimate, the average of window minima |
| base_o | output | SMP_W | Final baseline, the average of sub-threshold points |

## Verification
A wrong window count or a lost minimum shows at floor_o on the edge that closes the window. From the next sample on, it also shifts out_o. A fault in either averager's history memory stays hidden until the history wraps after 64 entries, so each stream runs well past that point. A misplaced threshold comparison or a wrapping subtraction changes base_o or out_o on the very next edge. Extreme-value streams push the floor to both rails to expose wrapping.

// File: rtl/bl_pkg.sv
package bl_pkg;
  localparam int unsigned SMP_W_DEF  = 16;
  localparam int unsigned WIN_W_DEF  = 8;
  localparam int unsigned AVG_LG_DEF = 6;
endpackage

// File: rtl/bl_sat_sub.sv
module bl_sat_sub #(
  parameter int unsigned W = 16
) (
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  output logic signed [W-1:0] y_o
);
  localparam logic signed [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

  logic signed [W:0] wide;
  assign wide = {a_i[W-1], a_i} - {b_i[W-1], b_i};

  always_comb begin
    if (wide[W] != wide[W-1]) y_o = wide[W] ? MIN_V : MAX_V;
    else                      y_o = wide[W-1:0];
  end
endmodule

// File: rtl/bl_win_min.sv
module bl_win_min #(
  parameter int unsigned SMP_W = 16,
  parameter int unsigned WIN_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic signed [SMP_W-1:0] smp_i,
  input  logic [WIN_W-1:0]        win_len_i,
  output logic                    push_o,
  output logic signed [SMP_W-1:0] min_o
);
  logic [WIN_W-1:0]        cnt_q;
  logic [WIN_W-1:0]        last;
  logic signed [SMP_W-1:0] cur_q;

  assign last   = (win_len_i == '0) ? '0 : win_len_i - WIN_W'(1);
  assign min_o  = (cnt_q == '0 || smp_i < cur_q) ? smp_i : cur_q;
  // >= so a shortened window closes at once
  assign push_o = valid_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cur_q <= '0;
    end else if (valid_i) begin
      cur_q <= min_o;
      cnt_q <= push_o ? '0 : cnt_q + WIN_W'(1);
    end
  end
endmodule

// File: rtl/bl_avg.sv
module bl_avg #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LG     = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     push_i,
  input  logic signed [DATA_W-1:0] din_i,
  output logic signed [DATA_W-1:0] avg_o
);
  localparam int unsigned DEPTH = 1 << LG;
  localparam int unsigned SUM_W = DATA_W + LG;
  localparam int unsigned CNT_W = LG + 1;

  logic signed [DATA_W-1:0] hist_q [DEPTH];
  logic [LG-1:0]            ptr_q;
  logic [CNT_W-1:0]         cnt_q;
  logic signed [SUM_W-1:0]  sum_q;
  logic                     full;
  logic signed [SUM_W-1:0]  din_ext;
  logic signed [SUM_W-1:0]  old_ext;
  logic signed [SUM_W-1:0]  divisor;

  assign full    = cnt_q[LG];
  assign din_ext = SUM_W'(din_i);
  assign old_ext = full ? SUM_W'(hist_q[ptr_q]) : '0;
  assign divisor = $signed({{(SUM_W-CNT_W){1'b0}}, cnt_q});
  // divide by live count: exact mean while filling
  assign avg_o   = (cnt_q == '0) ? '0 : DATA_W'(sum_q / divisor);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      cnt_q <= '0;
      sum_q <= '0;
    end else if (push_i) begin
      sum_q <= sum_q + din_ext - old_ext;
      ptr_q <= ptr_q + LG'(1);
      if (!full) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) hist_q[ptr_q] <= din_i;
  end
endmodule

// File: rtl/bl_restorer.sv
module bl_restorer
  import bl_pkg::*;
#(
  parameter int unsigned SMP_W  = SMP_W_DEF,
  parameter int unsigned WIN_W  = WIN_W_DEF,
  parameter int unsigned AVG_LG = AVG_LG_DEF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    smp_valid_i,
  input  logic signed [SMP_W-1:0] smp_i,
  input  logic [WIN_W-1:0]        win_len_i,
  input  logic signed [SMP_W-1:0] thresh_i,
  output logic                    out_valid_o,
  output logic signed [SMP_W-1:0] out_o,
  output logic signed [SMP_W-1:0] floor_o,
  output logic signed [SMP_W-1:0] base_o
);
  logic                    win_push;
  logic signed [SMP_W-1:0] win_min;
  logic signed [SMP_W-1:0] diff;
  logic signed [SMP_W-1:0] corr;
  logic                    below;

  bl_win_min #(.SMP_W(SMP_W), .WIN_W(WIN_W)) u_win (
    .clk_i, .rst_ni, .valid_i(smp_valid_i), .smp_i, .win_len_i,
    .push_o(win_push), .min_o(win_min)
  );

  bl_avg #(.DATA_W(SMP_W), .LG(AVG_LG)) u_floor (
    .clk_i, .rst_ni, .push_i(win_push), .din_i(win_min), .avg_o(floor_o)
  );

  bl_sat_sub #(.W(SMP_W)) u_diff (.a_i(smp_i), .b_i(floor_o), .y_o(diff));

  assign below = diff < thresh_i;

  bl_avg #(.DATA_W(SMP_W), .LG(AVG_LG)) u_base (
    .clk_i, .rst_ni, .push_i(smp_valid_i && below), .din_i(diff), .avg_o(base_o)
  );

  bl_sat_sub #(.W(SMP_W)) u_corr (.a_i(diff), .b_i(base_o), .y_o(corr));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_o       <= '0;
    end else begin
      out_valid_o <= smp_valid_i;
      if (smp_valid_i) out_o <= corr;
    end
  end
endmodule

// File: rtl/bl_restorer_chk.sv
module bl_restorer_chk #(
  parameter int unsigned SMP_W = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    smp_valid_i,
  input logic signed [SMP_W-1:0] thresh_i,
  input logic signed [SMP_W-1:0] diff_i,
  input logic                    out_valid_o,
  input logic signed [SMP_W-1:0] out_o,
  input logic signed [SMP_W-1:0] floor_o,
  input logic signed [SMP_W-1:0] base_o
);
  p_valid_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |=> out_valid_o);

  p_no_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> !out_valid_o);

  p_hold_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> ($stable(floor_o) && $stable(base_o) && $stable(out_o)));

  p_above_thr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && !(diff_i < thresh_i)) |=> $stable(base_o));
endmodule

bind bl_restorer bl_restorer_chk #(.SMP_W(SMP_W)) u_chk (
  .clk_i, .rst_ni, .smp_valid_i, .thresh_i, .diff_i(diff),
  .out_valid_o, .out_o, .floor_o, .base_o
);

// File: tb/bl_restorer_bench.sv
module bl_restorer_bench;
  localparam int W     = 16;
  localparam int DEPTH = 64;
  localparam int MAXV  = 32767;
  localparam int MINV  = -32768;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                smp_valid = 1'b0;
  logic signed [W-1:0] smp = '0;
  logic [7:0]          win_len = 8'd4;
  logic signed [W-1:0] thresh = '0;
  logic                out_valid;
  logic signed [W-1:0] out_v, floor_v, base_v;

  int checks = 0;
  int errors = 0;
  int qa[$];
  int qb[$];
  int mcnt = 0;
  int mcur = 0;
  int last_out = 0;
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  bl_restorer u_bl_restorer (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(smp_valid), .smp_i(smp),
    .win_len_i(win_len), .thresh_i(thresh), .out_valid_o(out_valid),
    .out_o(out_v), .floor_o(floor_v), .base_o(base_v)
  );

  function automatic int avg(input int q[$]);
    int s = 0;
    if (q.size() == 0) return 0;
    foreach (q[i]) s += q[i];
    return s / q.size();
  endfunction

  function automatic int sat(input int v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  function automatic int rnd(input int span);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 8) % span);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_sample(input int x);
    int fl, bs, df, eo, lastw;
    bit clamp, closes, pushed;
    @(negedge clk);
    smp_valid = 1'b1;
    smp = W'(x);
    fl = avg(qa);
    bs = avg(qb);
    df = sat(x - fl);
    eo = sat(df - bs);
    clamp = (df != x - fl) || (eo != df - bs);
    pushed = df < int'(thresh);
    if (pushed) begin
      qb.push_back(df);
      if (qb.size() > DEPTH) void'(qb.pop_front());
    end
    lastw = (win_len == 0) ? 0 : int'(win_len) - 1;
    mcur = (mcnt == 0 || x < mcur) ? x : mcur;
    closes = mcnt >= lastw;
    if (closes) begin
      qa.push_back(mcur);
      if (qa.size() > DEPTH) void'(qa.pop_front());
      mcnt = 0;
    end else mcnt++;
    @(posedge clk); #1;
    check(out_valid == 1'b1, "R7 out_valid", int'(out_valid), 1);
    if (clamp) check(int'(out_v) == eo, "R8 saturated out", int'(out_v), eo);
    else       check(int'(out_v) == eo, "R7 out", int'(out_v), eo);
    if (closes) check(int'(floor_v) == avg(qa), "R2 floor at window end", int'(floor_v), avg(qa));
    else        check(int'(floor_v) == avg(qa), "R3 floor hold", int'(floor_v), avg(qa));
    if (pushed) check(int'(base_v) == avg(qb), "R4 R5 base", int'(base_v), avg(qb));
    else        check(int'(base_v) == bs, "R6 base unchanged", int'(base_v), bs);
    last_out = eo;
  endtask

  task automatic do_idle();
    @(negedge clk);
    smp_valid = 1'b0;
    smp = W'(rnd(60000) - 30000);
    @(posedge clk); #1;
    check(out_valid == 1'b0, "R9 out_valid idle", int'(out_valid), 0);
    check(int'(out_v) == last_out, "R9 out hold", int'(out_v), last_out);
    check(int'(floor_v) == avg(qa), "R9 floor hold", int'(floor_v), avg(qa));
    check(int'(base_v) == avg(qb), "R9 base hold", int'(base_v), avg(qb));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R1 out_valid reset", int'(out_valid), 0);
    check(out_v == 0, "R1 out reset", int'(out_v), 0);
    check(floor_v == 0, "R1 floor reset", int'(floor_v), 0);
    check(base_v == 0, "R1 base reset", int'(base_v), 0);
    @(negedge clk);
    rst_n = 1'b1;
    do_idle();

    // drifting baseline with periodic peaks and gaps
    win_len = 8'd4;
    thresh = 16'sd40;
    for (int i = 0; i < 400; i++) begin
      int x = 100 + i / 20 + rnd(30) + ((i % 7 == 3) ? 500 : 0);
      do_sample(x);
      if (i % 5 == 4) do_idle();
    end

    // one-sample windows, including length 0
    win_len = 8'd0;
    thresh = 16'sd10;
    for (int i = 0; i < 80; i++) do_sample(rnd(400) - 200);
    win_len = 8'd1;
    for (int i = 0; i < 80; i++) do_sample(rnd(400) - 200);

    // saturation at both rails
    thresh = 16'sd32767;
    for (int i = 0; i < 140; i++) do_sample(MAXV);
    for (int i = 0; i < 10; i++) do_sample(MINV);
    thresh = -16'sd32768;
    for (int i = 0; i < 10; i++) do_sample(MINV + rnd(5));
    win_len = 8'd2;
    thresh = 16'sd32767;
    for (int i = 0; i < 140; i++) do_sample(MINV);
    for (int i = 0; i < 20; i++) do_sample(MAXV - rnd(3));

    // long window, noisy stream with peaks, threshold at the noise edge
    win_len = 8'd100;
    thresh = 16'sd0;
    for (int i = 0; i < 800; i++) begin
      int x = -300 + rnd(50) + ((rnd(9) == 0) ? 2000 : 0);
      do_sample(x);
      if (rnd(6) == 0) do_idle();
    end

    // window length changed mid-window
    win_len = 8'd7;
    for (int i = 0; i < 5; i++) do_sample(rnd(100));
    win_len = 8'd3;
    for (int i = 0; i < 30; i++) do_sample(rnd(100));
    do_idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule